// File: doc/BRIEF.md
# Bus Hold Acknowledge Controller

This block sits on the processor side of a shared external bus. It hands the bus to another master when that master raises a hold request. It follows the bus cycle that is currently running, including burst reads that end after a fixed number of ready strobes, and it lets that cycle finish before it grants. The grant lands a fixed two clocks after the final ready strobe. In that same clock the bus drivers are switched off and no new cycle is allowed to start.

While the bus is granted, the other master may run a cache snoop by pulsing an inquire strobe. The snoop result appears a fixed number of clocks later. The grant is held until that result has been presented, even if the hold request has already gone away. After release, the internal request queue may start cycles again.

Top module: `hold_ack_ctrl`

## Requirements
- R1: Immediately after reset, `hlda` is 0, `bus_oe` is 1 and `cyc_ok` is 1.
- R2: If `hold_req` is sampled high at a clock edge while no bus cycle is running or starting, `hlda` rises after the second following edge (two clocks later).
- R3: A cycle accepted in the same clock that `hold_req` is first sampled high is not aborted. A burst cycle (`cyc_burst`=1 at start) ends on its fourth `brdy` (BURST_LEN), with any number of idle clocks between strobes. A single cycle (`cyc_burst`=0) ends on its only `brdy`.
- R4: `hlda` rises exactly two clocks after the edge that samples the last `brdy` of the cycle in progress, and not earlier.
- R5: `bus_oe` falls in the same clock that `hlda` rises and stays low for as long as `hlda` is high.
- R6: `cyc_ok` is low while a grant is pending and while `hlda` is high. A `cyc_start` that is sampled while `cyc_ok` is low is ignored and does not delay a later grant.
- R7: With no snoop outstanding, `hlda` falls one clock after `hold_req` is sampled low. `bus_oe` and `cyc_ok` return to 1 in that same clock.
- R8: A `snoop_strobe` sampled while the bus is granted, including the edge at which `hold_req` is first sampled low, holds `hlda` high until three clocks after that strobe. This is one clock after the result, which appears RES_LAT=2 clocks after the strobe.
- R9: A `snoop_strobe` sampled in the clock after `hold_req` was sampled low is ignored and does not delay the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req | input | 1 | Request from another master to take the bus |
| cyc_start | input | 1 | The request queue starts a bus cycle this clock (taken only when `cyc_ok` is high) |
| cyc_burst | input | 1 | With `cyc_start`: 1 = burst cycle, 0 = single transfer |
| brdy | input | 1 | Ready strobe; one per completed transfer |
| snoop_strobe | input | 1 | Inquire strobe from the other master |
| hlda | output | 1 | Hold acknowledge |
| bus_oe | output | 1 | Global enable for the address, data and control drivers |
| cyc_ok | output | 1 | Permission for the request queue to start a cycle |

## Verification
The bench builds the block with its defaults: a four-beat burst, a two-clock grant delay and a two-clock snoop result latency. With these values every timing the requirements quote is an exact cycle count that the bench can compare at the ports. The burst stimulus places an idle clock after the third strobe, so a grant that fired on the wrong beat would show up. The snoop cases use the strobe one clock before the hold drop, in the drop clock and one clock after it. These three positions bring both the extended release and the ignored strobe within reach.

// File: rtl/hac_pkg.sv
package hac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PEND = 3'd1,
    ST_GAP  = 3'd2,
    ST_HELD = 3'd3,
    ST_REL  = 3'd4
  } hac_state_e;

endpackage

// File: rtl/hac_cycle_track.sv
module hac_cycle_track #(
  parameter int BURST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_v,
  input  logic burst,
  input  logic brdy,
  output logic active,
  output logic last_beat
);

  localparam int CW = $clog2(BURST_LEN + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(BURST_LEN - 1);

  logic          act_q, act_d;
  logic          bur_q, bur_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign active    = act_q;
  assign last_beat = act_q && brdy && (!bur_q || (cnt_q == LAST_IDX));

  always_comb begin
    act_d = act_q;
    bur_d = bur_q;
    cnt_d = cnt_q;
    if (start_v) begin
      act_d = 1'b1;
      bur_d = burst;
      cnt_d = '0;
    end else if (act_q && brdy) begin
      if (last_beat) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      bur_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      bur_q <= bur_d;
      cnt_q <= cnt_d;
    end
  end

  AST_BEAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(BURST_LEN)); // R3

  AST_SINGLE_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !bur_q) |-> (cnt_q == '0)); // R3

endmodule

// File: rtl/hac_snoop_timer.sv
module hac_snoop_timer #(
  parameter int RES_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic accept,
  output logic busy
);

  localparam int TW = $clog2(RES_LAT + 1);
  localparam logic [TW-1:0] LOAD = TW'(RES_LAT);

  logic [TW-1:0] tmr_q, tmr_d;

  assign busy = (tmr_q != '0);

  always_comb begin
    tmr_d = tmr_q;
    if (strobe && accept) begin
      tmr_d = LOAD;
    end else if (tmr_q != '0) begin
      tmr_d = tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else begin
      tmr_q <= tmr_d;
    end
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_q <= LOAD); // R8

  AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(strobe && accept)) |=> (tmr_q == $past(tmr_q) - 1'b1)); // R8

endmodule

// File: rtl/hac_grant_fsm.sv
module hac_grant_fsm
  import hac_pkg::*;
#(
  parameter int GRANT_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  input  logic cyc_busy,
  input  logic last_beat,
  input  logic snoop_busy,
  output logic held,
  output logic hlda,
  output logic bus_oe,
  output logic cyc_ok
);

  localparam int GW = $clog2(GRANT_DLY + 1);
  localparam logic [GW-1:0] GAP_LOAD = GW'(GRANT_DLY - 1);

  hac_state_e    st_q, st_d;
  logic [GW-1:0] gap_q, gap_d;
  logic          hlda_q, oe_q, ok_q;
  logic          grant_d;

  assign held   = (st_q == ST_HELD);
  assign hlda   = hlda_q;
  assign bus_oe = oe_q;
  assign cyc_ok = ok_q;

  always_comb begin
    st_d  = st_q;
    gap_d = gap_q;
    unique case (st_q)
      ST_IDLE: begin
        if (hold_req) begin
          if (cyc_busy) begin
            st_d = ST_PEND;
          end else begin
            st_d  = ST_GAP;
            gap_d = GAP_LOAD;
          end
        end
      end
      ST_PEND: begin
        if (!hold_req) begin
          st_d = ST_IDLE;
        end else if (last_beat) begin
          st_d  = ST_GAP;
          gap_d = GAP_LOAD;
        end
      end
      ST_GAP: begin
        if (!hold_req) begin
          st_d = ST_IDLE;
        end else if (gap_q == '0) begin
          st_d = ST_HELD;
        end else begin
          gap_d = gap_q - 1'b1;
        end
      end
      ST_HELD: begin
        if (!hold_req) begin
          st_d = ST_REL;
        end
      end
      ST_REL: begin
        if (!snoop_busy) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign grant_d = (st_d == ST_HELD) || (st_d == ST_REL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      gap_q  <= '0;
      hlda_q <= 1'b0;
      oe_q   <= 1'b1;
      ok_q   <= 1'b1;
    end else begin
      st_q   <= st_d;
      gap_q  <= gap_d;
      hlda_q <= grant_d;
      oe_q   <= !grant_d;
      ok_q   <= (st_d == ST_IDLE);
    end
  end

  AST_GRANT_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda_q) |-> $past(hold_req)); // R2

  AST_RELEASE_FROM_REL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hlda_q) |-> ($past(st_q) == ST_REL)); // R7

  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= GAP_LOAD); // R4

endmodule

// File: rtl/hold_ack_ctrl.sv
module hold_ack_ctrl #(
  parameter int BURST_LEN = 4,
  parameter int GRANT_DLY = 2,
  parameter int RES_LAT   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  input  logic cyc_start,
  input  logic cyc_burst,
  input  logic brdy,
  input  logic snoop_strobe,
  output logic hlda,
  output logic bus_oe,
  output logic cyc_ok
);

  logic start_v;
  logic trk_active;
  logic trk_last;
  logic cyc_busy;
  logic held;
  logic snp_busy;

  assign start_v  = cyc_start && cyc_ok;
  assign cyc_busy = start_v || (trk_active && !trk_last);

  hac_cycle_track #(.BURST_LEN(BURST_LEN)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_v   (start_v),
    .burst     (cyc_burst),
    .brdy      (brdy),
    .active    (trk_active),
    .last_beat (trk_last)
  );

  hac_snoop_timer #(.RES_LAT(RES_LAT)) u_snoop (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (snoop_strobe),
    .accept (held),
    .busy   (snp_busy)
  );

  hac_grant_fsm #(.GRANT_DLY(GRANT_DLY)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_req   (hold_req),
    .cyc_busy   (cyc_busy),
    .last_beat  (trk_last),
    .snoop_busy (snp_busy),
    .held       (held),
    .hlda       (hlda),
    .bus_oe     (bus_oe),
    .cyc_ok     (cyc_ok)
  );

  AST_FLOAT_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> !bus_oe); // R5

  AST_NO_START_IN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> !cyc_ok); // R6

  AST_GRANT_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> !trk_active); // R4

  AST_RELEASE_AFTER_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hlda) |-> !$past(snp_busy)); // R8

endmodule

// File: tb/hold_ack_ctrl_bench.sv
`timescale 1ns/1ps
module hold_ack_ctrl_bench;

  logic clk;
  logic rst_n;
  logic hold_req, cyc_start, cyc_burst, brdy, snoop_strobe;
  logic hlda, bus_oe, cyc_ok;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  hold_ack_ctrl u_hold_ack_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold_req     (hold_req),
    .cyc_start    (cyc_start),
    .cyc_burst    (cyc_burst),
    .brdy         (brdy),
    .snoop_strobe (snoop_strobe),
    .hlda         (hlda),
    .bus_oe       (bus_oe),
    .cyc_ok       (cyc_ok)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic grant_idle();
    hold_req = 1'b1;
    step();
    chk("R2", "hlda one clock after hold", hlda, 1'b0);
    chk("R6", "cyc_ok while pending", cyc_ok, 1'b0);
    step();
    chk("R2", "hlda two clocks after hold edge-1", hlda, 1'b0);
    step();
    chk("R2", "hlda after idle-path delay", hlda, 1'b1);
    chk("R5", "bus_oe with grant", bus_oe, 1'b0);
  endtask

  task automatic release_plain();
    hold_req = 1'b0;
    step();
    chk("R7", "hlda same clock as hold low", hlda, 1'b1);
    step();
    chk("R7", "hlda dropped", hlda, 1'b0);
    chk("R7", "bus_oe restored", bus_oe, 1'b1);
    chk("R7", "cyc_ok restored", cyc_ok, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1", "hlda at reset", hlda, 1'b0);
    chk("R1", "bus_oe at reset", bus_oe, 1'b1);
    chk("R1", "cyc_ok at reset", cyc_ok, 1'b1);
  endtask

  task automatic t_idle();
    grant_idle();
    step();
    chk("R5", "bus_oe held low", bus_oe, 1'b0);
    chk("R6", "cyc_ok low while granted", cyc_ok, 1'b0);
    release_plain();
  endtask

  task automatic t_burst();
    logic [5:0] pat;
    pat = 6'b101101;
    cyc_start = 1'b1; cyc_burst = 1'b1; hold_req = 1'b1;
    step();
    cyc_start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      brdy = pat[i];
      step();
      chk("R3", "no grant during burst", hlda, 1'b0);
    end
    brdy = 1'b0;
    step();
    chk("R4", "no grant one clock after last brdy", hlda, 1'b0);
    step();
    chk("R4", "grant two clocks after last brdy", hlda, 1'b1);
    chk("R5", "bus_oe falls with grant", bus_oe, 1'b0);
    release_plain();
  endtask

  task automatic t_single();
    cyc_start = 1'b1; cyc_burst = 1'b0; hold_req = 1'b1;
    step();
    cyc_start = 1'b0;
    step();
    chk("R3", "single waits for brdy", hlda, 1'b0);
    brdy = 1'b1;
    step();
    brdy = 1'b0;
    chk("R4", "single: no grant at brdy", hlda, 1'b0);
    step();
    chk("R4", "single: no grant +1", hlda, 1'b0);
    step();
    chk("R3", "single ends on one brdy", hlda, 1'b1);
    release_plain();
  endtask

  task automatic t_snoop_before();
    grant_idle();
    snoop_strobe = 1'b1;
    step();
    snoop_strobe = 1'b0; hold_req = 1'b0;
    step();
    chk("R8", "snoop early +1", hlda, 1'b1);
    step();
    chk("R8", "snoop early +2", hlda, 1'b1);
    step();
    chk("R8", "snoop early +3 released", hlda, 1'b0);
    chk("R8", "bus_oe after snoop release", bus_oe, 1'b1);
  endtask

  task automatic t_snoop_same();
    grant_idle();
    snoop_strobe = 1'b1; hold_req = 1'b0;
    step();
    snoop_strobe = 1'b0;
    chk("R8", "snoop same +0", hlda, 1'b1);
    step();
    chk("R8", "snoop same +1 still held", hlda, 1'b1);
    step();
    chk("R8", "snoop same +2 still held", hlda, 1'b1);
    step();
    chk("R8", "snoop same +3 released", hlda, 1'b0);
  endtask

  task automatic t_snoop_late();
    grant_idle();
    hold_req = 1'b0;
    step();
    snoop_strobe = 1'b1;
    step();
    snoop_strobe = 1'b0;
    chk("R9", "late strobe ignored", hlda, 1'b0);
    step();
    chk("R9", "late strobe: stays released", hlda, 1'b0);
    chk("R9", "late strobe: cyc_ok", cyc_ok, 1'b1);
  endtask

  task automatic t_start_blocked();
    grant_idle();
    cyc_start = 1'b1; cyc_burst = 1'b1;
    step();
    step();
    cyc_start = 1'b0;
    release_plain();
    grant_idle();
    chk("R6", "ignored start did not delay grant", hlda, 1'b1);
    release_plain();
  endtask

  initial begin
    rst_n = 1'b0;
    hold_req = 1'b0; cyc_start = 1'b0; cyc_burst = 1'b0;
    brdy = 1'b0; snoop_strobe = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_idle();
    t_burst();
    t_single();
    t_snoop_before();
    t_snoop_same();
    t_snoop_late();
    t_start_blocked();
    step();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule